// File: doc/BRIEF.md
# Time-Slotted Broadcast Bus Node

This block is the slot-timing core of one node on a shared broadcast bus in which time is split into fixed slots. A free-running slot counter advances once per tick strobe and wraps at a configured cycle length, so the slot index is always the tick count modulo that length. A per-node bitmap marks the slots this node owns. The slot counter and the bitmap are loaded while the node is held in reset.

In a tick whose slot the node owns, three things happen. The node asks its host for a message by presenting the slot index. It places the host's reply on its transmit port. It blanks its store port, so it never records its own frame. In any slot it does not own, it transmits nothing and hands whatever word is on the bus to its store port.

Each port is a valid bit plus a data field, and the data field is forced to zero whenever valid is low. Because of this, a cluster can merge the transmit ports of all its nodes with a plain OR. All nodes in the cluster share one cycle length and have slot bitmaps that do not overlap. Under that arrangement at most one node drives the bus in any tick.

Top module: `tdma_slot_node`

## Requirements
- R1: The first tick after reset is slot 0. Each later tick advances the slot by one. After slot L-1 the slot returns to 0, where L is the loaded cycle length. A loaded length of 0, or any length above MAX_SLOTS, behaves as MAX_SLOTS.
- R2: The cycle length and the slot bitmap are captured only on clock edges where the reset input is low and cfg_we is high. A cfg_we pulse while the node runs has no effect on later slots.
- R3: Outputs respond only in the clock cycle that follows an edge where tick was high. In every other cycle, including during reset, fetch_valid, tx_valid and store_valid are low.
- R4: Bit i of cfg_slot_map marks slot i as owned. In the response cycle of an owned slot s, fetch_valid is high and fetch_slot equals s.
- R5: In an owned slot, tx_valid equals host_valid and tx_data equals host_data in that response cycle.
- R6: In an owned slot, store_valid is low whatever the bus carries.
- R7: In a slot the node does not own, fetch_valid and tx_valid stay low even if the host offers a message. Whenever tx_valid is low, tx_data is all zeros.
- R8: In a slot the node does not own, store_valid equals bus_valid and store_data equals bus_data. store_data is zero whenever store_valid is low.
- R9: store_valid is never high in the same cycle as fetch_valid or tx_valid.
- R10: Nodes with a shared cycle length and disjoint bitmaps, joined by an OR bus, never have two transmitters in one tick. Every non-owner stores exactly the owner's message, and all store ports are empty when nobody sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the configuration is loaded while it is low |
| cfg_we | input | 1 | Configuration capture enable, honoured only in reset |
| cfg_cycle_len | input | SLOT_W+1 | Cycle length in slots (0 means MAX_SLOTS) |
| cfg_slot_map | input | MAX_SLOTS | Owned-slot bitmap, bit i = slot i |
| tick | input | 1 | Slot-advance strobe |
| host_valid | input | 1 | Host has a message for the current owned slot |
| host_data | input | DATA_W | Host message |
| bus_valid | input | 1 | Bus word present |
| bus_data | input | DATA_W | Bus word |
| fetch_valid | output | 1 | Message request to the host |
| fetch_slot | output | SLOT_W | Slot index carried with the request |
| tx_valid | output | 1 | Transmit word present |
| tx_data | output | DATA_W | Transmit word, zero when idle |
| store_valid | output | 1 | Received word present |
| store_data | output | DATA_W | Received word, zero when idle |

## Verification
The bench builds a three-node cluster on an OR bus, plus an injected word in unowned slots. It then walks a full cycle twice, with hosts offering messages in slots they do not own. A node that leaked those offers would put two drivers on the bus, and a node that did not blank reception would store its own frame. The cycle-wrap boundary is exercised with length 8 and with length 0, which must wrap at 64; an off-by-one compare would shift every later owned slot. A configuration write while running, and the idle cycles between ticks, catch a node that keeps listening to configuration or holds its outputs valid for longer than one cycle.

// File: rtl/tdma_node_pkg.sv
`timescale 1ns/1ps
package tdma_node_pkg;

   function automatic int slot_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/tdma_slot_counter.sv
`timescale 1ns/1ps
module tdma_slot_counter #(
   parameter int SLOT_W = 6,
   localparam int LEN_W = SLOT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [LEN_W-1:0]  cfg_cycle_len,
   input  logic              tick,
   output logic [SLOT_W-1:0] cur_slot
);
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] last_slot;
   logic             at_end;

   // configuration flops carry no reset: they are written only during reset
   always_ff @(posedge clk) begin
      if (!rst_n && cfg_we) len_q <= cfg_cycle_len;
   end

   // length 0 or above the slot range never matches and wraps naturally
   assign last_slot = len_q - LEN_W'(1);
   assign at_end    = ({1'b0, cur_slot} == last_slot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cur_slot <= '0;
      else if (tick) cur_slot <= at_end ? '0 : cur_slot + SLOT_W'(1);
   end
endmodule

// File: rtl/tdma_slot_lookup.sv
`timescale 1ns/1ps
module tdma_slot_lookup #(
   parameter int MAX_SLOTS    = 64,
   parameter int SLOT_W       = 6,
   parameter int LOOKUP_STYLE = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [MAX_SLOTS-1:0] cfg_slot_map,
   input  logic                 tick,
   input  logic [SLOT_W-1:0]    cur_slot,
   output logic                 phase_q,
   output logic                 active_q,
   output logic [SLOT_W-1:0]    slot_q
);
   logic [MAX_SLOTS-1:0] map_q;
   logic                 hit;

   always_ff @(posedge clk) begin
      if (!rst_n && cfg_we) map_q <= cfg_slot_map;
   end

   generate
      if (LOOKUP_STYLE == 0) begin : g_indexed
         assign hit = map_q[cur_slot];
      end else begin : g_decoded
         logic [MAX_SLOTS-1:0] sel;
         for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_bit
            assign sel[i] = map_q[i] && (cur_slot == SLOT_W'(i));
         end
         assign hit = |sel;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= 1'b0;
         active_q <= 1'b0;
         slot_q   <= '0;
      end else begin
         phase_q <= tick;
         if (tick) begin
            active_q <= hit;
            slot_q   <= cur_slot;
         end
      end
   end
endmodule

// File: rtl/tdma_port_gate.sv
`timescale 1ns/1ps
module tdma_port_gate #(
   parameter int DATA_W = 16,
   parameter int SLOT_W = 6
) (
   input  logic              phase,
   input  logic              active,
   input  logic [SLOT_W-1:0] slot,
   input  logic              host_valid,
   input  logic [DATA_W-1:0] host_data,
   input  logic              bus_valid,
   input  logic [DATA_W-1:0] bus_data,
   output logic              fetch_valid,
   output logic [SLOT_W-1:0] fetch_slot,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              store_valid,
   output logic [DATA_W-1:0] store_data
);
   logic own_now;
   logic listen_now;

   assign own_now    = phase && active;
   assign listen_now = phase && !active;

   assign fetch_valid = own_now;
   assign fetch_slot  = own_now ? slot : '0;
   assign tx_valid    = own_now && host_valid;
   assign tx_data     = tx_valid ? host_data : '0;
   assign store_valid = listen_now && bus_valid;
   assign store_data  = store_valid ? bus_data : '0;
endmodule

// File: rtl/tdma_slot_node.sv
`timescale 1ns/1ps
module tdma_slot_node #(
   parameter int DATA_W       = 16,
   parameter int MAX_SLOTS    = 64,
   parameter int LOOKUP_STYLE = 0,
   localparam int SLOT_W = tdma_node_pkg::slot_bits(MAX_SLOTS),
   localparam int LEN_W  = SLOT_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [LEN_W-1:0]     cfg_cycle_len,
   input  logic [MAX_SLOTS-1:0] cfg_slot_map,
   input  logic                 tick,
   input  logic                 host_valid,
   input  logic [DATA_W-1:0]    host_data,
   input  logic                 bus_valid,
   input  logic [DATA_W-1:0]    bus_data,
   output logic                 fetch_valid,
   output logic [SLOT_W-1:0]    fetch_slot,
   output logic                 tx_valid,
   output logic [DATA_W-1:0]    tx_data,
   output logic                 store_valid,
   output logic [DATA_W-1:0]    store_data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (MAX_SLOTS < 2 || MAX_SLOTS > 64 || !tdma_node_pkg::is_pow2(MAX_SLOTS)) begin : g_bad_slots
         $error("MAX_SLOTS must be a power of two from 2 to 64");
      end
      if (LOOKUP_STYLE != 0 && LOOKUP_STYLE != 1) begin : g_bad_style
         $error("LOOKUP_STYLE must be 0 or 1");
      end
   endgenerate

   logic [SLOT_W-1:0] cur_slot;
   logic              phase_q;
   logic              active_q;
   logic [SLOT_W-1:0] slot_q;

   tdma_slot_counter #(.SLOT_W(SLOT_W)) u_counter (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_cycle_len (cfg_cycle_len),
      .tick          (tick),
      .cur_slot      (cur_slot)
   );

   tdma_slot_lookup #(
      .MAX_SLOTS    (MAX_SLOTS),
      .SLOT_W       (SLOT_W),
      .LOOKUP_STYLE (LOOKUP_STYLE)
   ) u_lookup (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_slot_map (cfg_slot_map),
      .tick         (tick),
      .cur_slot     (cur_slot),
      .phase_q      (phase_q),
      .active_q     (active_q),
      .slot_q       (slot_q)
   );

   tdma_port_gate #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_gate (
      .phase       (phase_q),
      .active      (active_q),
      .slot        (slot_q),
      .host_valid  (host_valid),
      .host_data   (host_data),
      .bus_valid   (bus_valid),
      .bus_data    (bus_data),
      .fetch_valid (fetch_valid),
      .fetch_slot  (fetch_slot),
      .tx_valid    (tx_valid),
      .tx_data     (tx_data),
      .store_valid (store_valid),
      .store_data  (store_data)
   );
endmodule

// File: rtl/tdma_slot_node_chk.sv
`timescale 1ns/1ps
module tdma_slot_node_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              host_valid,
   input logic [DATA_W-1:0] host_data,
   input logic              bus_valid,
   input logic [DATA_W-1:0] bus_data,
   input logic              fetch_valid,
   input logic              tx_valid,
   input logic [DATA_W-1:0] tx_data,
   input logic              store_valid,
   input logic [DATA_W-1:0] store_data
);
   // R3: nothing is presented unless the previous edge saw a tick
   p_gap_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> !(fetch_valid || tx_valid || store_valid));

   // R5: owned slot forwards the host word
   p_tx_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (tx_valid == host_valid) && (!host_valid || tx_data == host_data));

   // R7: no transmission without a request, idle data is zero
   p_tx_needs_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> fetch_valid);
   p_tx_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |-> (tx_data == '0));

   // R8: stored word is the bus word
   p_store_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
      store_valid |-> bus_valid && (store_data == bus_data));

   // R9: own slot never stores
   p_no_self_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid || tx_valid) |-> !store_valid);
endmodule

bind tdma_slot_node tdma_slot_node_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .host_valid  (host_valid),
   .host_data   (host_data),
   .bus_valid   (bus_valid),
   .bus_data    (bus_data),
   .fetch_valid (fetch_valid),
   .tx_valid    (tx_valid),
   .tx_data     (tx_data),
   .store_valid (store_valid),
   .store_data  (store_data)
);

// File: tb/tdma_slot_node_tb.sv
`timescale 1ns/1ps
module tdma_slot_node_tb;
   localparam int DW = 16;
   localparam int NS = 64;
   localparam int SW = 6;
   localparam int LW = 7;
   localparam int NN = 3;

   // vector bits: {ext_valid, host_valid node2, node1, node0}
   localparam logic [3:0] VEC [16] = '{
      4'b0111, 4'b0010, 4'b0100, 4'b0000, 4'b0111, 4'b0011, 4'b1000, 4'b1000,
      4'b0001, 4'b0000, 4'b0111, 4'b0001, 4'b0000, 4'b0010, 4'b0000, 4'b0111 };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [LW-1:0] cfg_len = '0;
   logic [NS-1:0] cfg_map [NN];
   logic tick = 1'b0;
   logic hv [NN];
   logic [DW-1:0] hd [NN];
   logic ext_v = 1'b0;
   logic [DW-1:0] ext_d = '0;
   logic fv [NN];
   logic [SW-1:0] fs [NN];
   logic tv [NN];
   logic [DW-1:0] td [NN];
   logic sv [NN];
   logic [DW-1:0] sd [NN];
   logic bus_v;
   logic [DW-1:0] bus_d;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int len_eff = 8;
   logic [NS-1:0] map_b [NN];

   always #10 clk = ~clk;

   assign bus_v = tv[0] | tv[1] | tv[2] | ext_v;
   assign bus_d = td[0] | td[1] | td[2] | (ext_v ? ext_d : '0);

   tdma_slot_node #(.DATA_W(DW), .MAX_SLOTS(NS), .LOOKUP_STYLE(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cycle_len(cfg_len),
      .cfg_slot_map(cfg_map[0]), .tick(tick), .host_valid(hv[0]), .host_data(hd[0]),
      .bus_valid(bus_v), .bus_data(bus_d), .fetch_valid(fv[0]), .fetch_slot(fs[0]),
      .tx_valid(tv[0]), .tx_data(td[0]), .store_valid(sv[0]), .store_data(sd[0]));

   tdma_slot_node #(.DATA_W(DW), .MAX_SLOTS(NS), .LOOKUP_STYLE(1)) u_peer1 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cycle_len(cfg_len),
      .cfg_slot_map(cfg_map[1]), .tick(tick), .host_valid(hv[1]), .host_data(hd[1]),
      .bus_valid(bus_v), .bus_data(bus_d), .fetch_valid(fv[1]), .fetch_slot(fs[1]),
      .tx_valid(tv[1]), .tx_data(td[1]), .store_valid(sv[1]), .store_data(sd[1]));

   tdma_slot_node #(.DATA_W(DW), .MAX_SLOTS(NS), .LOOKUP_STYLE(0)) u_peer2 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cycle_len(cfg_len),
      .cfg_slot_map(cfg_map[2]), .tick(tick), .host_valid(hv[2]), .host_data(hd[2]),
      .bus_valid(bus_v), .bus_data(bus_d), .fetch_valid(fv[2]), .fetch_slot(fs[2]),
      .tx_valid(tv[2]), .tx_data(td[2]), .store_valid(sv[2]), .store_data(sd[2]));

   function automatic logic [DW-1:0] msg(input int i, input int k);
      return {2'(i), 2'b00, 12'(k)};
   endfunction

   function automatic logic [DW-1:0] ext_word(input int k);
      return {4'hE, 12'(k)};
   endfunction

   task automatic chk(input bit ok, input string tag, input string ctx,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, ctx, act, exp);
      end
   endtask

   task automatic all_quiet(input string tag, input string ctx);
      for (int i = 0; i < NN; i++) begin
         chk(!fv[i] && !tv[i] && !sv[i] && td[i] == '0 && sd[i] == '0, tag, ctx,
             {61'b0, fv[i], tv[i], sv[i]}, 64'h0);
      end
   endtask

   task automatic configure(input int len, input logic [NS-1:0] m0,
                            input logic [NS-1:0] m1, input logic [NS-1:0] m2);
      @(negedge clk);
      rst_n = 1'b0;
      tick = 1'b1;
      cfg_we = 1'b1;
      cfg_len = LW'(len);
      cfg_map[0] = m0; cfg_map[1] = m1; cfg_map[2] = m2;
      map_b[0] = m0; map_b[1] = m1; map_b[2] = m2;
      len_eff = (len == 0 || len > NS) ? NS : len;
      @(negedge clk);
      @(negedge clk);
      all_quiet("R3", "during reset with tick high");
      cfg_we = 1'b0;
      tick = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_tick(input int k, input logic [3:0] v, input string ctx);
      int s;
      int own_n;
      logic bv;
      logic [DW-1:0] bd;
      string c;
      s = k % len_eff;
      own_n = -1;
      for (int i = 0; i < NN; i++) if (map_b[i][s]) own_n = i;
      c = $sformatf("%s tick %0d slot %0d", ctx, k, s);
      @(negedge clk);
      tick = 1'b1;
      for (int i = 0; i < NN; i++) begin
         hv[i] = v[i];
         hd[i] = msg(i, k);
      end
      ext_v = v[3];
      ext_d = ext_word(k);
      @(negedge clk);
      tick = 1'b0;
      bv = v[3] || (own_n >= 0 && v[own_n]);
      bd = (v[3] ? ext_word(k) : '0) | ((own_n >= 0 && v[own_n]) ? msg(own_n, k) : '0);
      for (int i = 0; i < NN; i++) begin
         logic own, etx, est;
         own = (own_n == i);
         etx = own && v[i];
         est = !own && bv;
         chk(fv[i] == own, "R4", c, 64'(fv[i]), 64'(own));
         if (own) chk(fs[i] == SW'(s), "R1/R4", c, 64'(fs[i]), 64'(s));
         chk(tv[i] == etx, "R5/R7", c, 64'(tv[i]), 64'(etx));
         chk(td[i] == (etx ? msg(i, k) : '0), "R5/R7", c, 64'(td[i]),
             64'(etx ? msg(i, k) : '0));
         chk(sv[i] == est, "R6/R8", c, 64'(sv[i]), 64'(est));
         chk(sd[i] == (est ? bd : '0), "R8/R10", c, 64'(sd[i]), 64'(est ? bd : '0));
         chk(!(sv[i] && (fv[i] || tv[i])), "R9", c, 64'(sv[i]), 64'h0);
      end
      chk((32'(tv[0]) + 32'(tv[1]) + 32'(tv[2])) <= 1, "R10", c,
          64'(32'(tv[0]) + 32'(tv[1]) + 32'(tv[2])), 64'h1);
      for (int i = 0; i < NN; i++) hv[i] = 1'b0;
      ext_v = 1'b0;
      @(negedge clk);
      all_quiet("R3", {"gap after ", c});
   endtask

   initial begin
      for (int i = 0; i < NN; i++) begin
         hv[i] = 1'b0;
         hd[i] = '0;
         cfg_map[i] = '0;
         map_b[i] = '0;
      end
      // slots: 0,3 node0; 1,5 node1; 2 node2; 4,6,7 unowned
      configure(8, 64'h09, 64'h22, 64'h04);
      // R2: a configuration write while running must be ignored
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_len = LW'(3);
      for (int i = 0; i < NN; i++) cfg_map[i] = '1;
      repeat (2) @(negedge clk);
      cfg_we = 1'b0;
      for (int k = 0; k < 16; k++) run_tick(k, VEC[k], "R2 table walk");
      // R1: length 0 acts as full 64-slot cycle
      configure(0, 64'h8000_0000_0000_0001, 64'h0, 64'h0);
      for (int k = 0; k < 66; k++) run_tick(k, 4'b0001, "len0 wrap");
      // R1: length 1 keeps every tick on slot 0
      configure(1, 64'h0, 64'h1, 64'h0);
      for (int k = 0; k < 4; k++) run_tick(k, 4'b0111, "len1");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule